// File: doc/BRIEF.md
# Block Lookup Table Region Attribute Sequencer

This block walks a bit-per-block security lookup table and either marks an address region secure or non-secure, or reports what attribute the region currently holds. Each table word covers 32 consecutive blocks. The block size is two to the power of a run-time exponent, and a bit at 1 means non-secure.

A caller presents a base and an inclusive limit address, together with the base address and table offset of the memory range the region lies in, and pulses `start`. The sequencer first converts both addresses to block and word indices and checks them. It then reaches the table through a read port with one cycle of latency and a separate write port, and handles one word per step. Boundary words that are only partly covered get a read-modify-write under a computed mask. Words that are fully covered are written outright during updates. A query folds the words together and stops as soon as the answer is known to be mixed. At the end, a single-cycle `done` pulse carries an error code and, for queries, the attribute.

Top module: `lut_attr_engine`

## Requirements
- R1: If `base_addr` or `limit_addr`+1 has any bit set below bit `blk_exp`, the operation ends with `err`=1 (misaligned). `done` rises in the cycle after the start edge, `busy` never rises, and the table is neither read nor written.
- R2: A block index is computed as (address − `rng_base` + `rng_off`) >> `blk_exp`. Its word index is block index >> 5, and its bit within the word is block index mod 32.
- R3: A base block index above the limit block index ends the operation with `err`=2 (bad range) and no table access.
- R4: If either word index exceeds `max_word`, the result is `err`=2 with no table access. Word indices equal to `max_word` are accepted.
- R5: `op`=1 sets to 1 every bit from the base block to the limit block. The first word's bits below the base bit and the last word's bits above the limit bit keep their values.
- R6: `op`=0 clears to 0 exactly the bits of the region and leaves every other bit unchanged.
- R7: When both ends fall in one word, only the bits between them change. A region that ends on bit 31 of its last word includes that bit.
- R8: Each boundary word takes one read and one write over two busy cycles, and each interior word takes one write and no read in one busy cycle. For N≥2 words, `busy` is high for N+2 cycles, with 2 reads and N writes; a single word takes 2 cycles.
- R9: `op`=2 or 3 queries the region, returning `attr`=0 (secure) if all region bits are 0, 1 (non-secure) if all are 1, and 2 (mixed) otherwise. Only region bits count in the first and last words.
- R10: A query stops after the first word whose region bits are mixed or whose attribute differs from the earlier words, and returns mixed. Each word queried takes two busy cycles.
- R11: `start` is ignored while `busy` is high. The running operation completes unchanged, and only one `done` pulse follows.
- R12: After reset, `busy`, `done`, `lut_rd_en` and `lut_wr_en` are low and `err` and `attr` are 0.
- R13: `done` is high for exactly one cycle per accepted operation, in the first cycle with `busy` low. The read port is used only while busy and never names the word that the write port is writing in the same cycle. `err`=0 on success, and `attr`=2 for updates and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 2 | 0 set secure, 1 set non-secure, 2/3 query |
| base_addr | input | ADDR_W | First byte of the region |
| limit_addr | input | ADDR_W | Last byte of the region (inclusive) |
| rng_base | input | ADDR_W | Base address of the memory range |
| rng_off | input | ADDR_W | Table byte offset of that range |
| blk_exp | input | EXP_W | Log2 of the block size in bytes |
| max_word | input | IDX_W | Highest valid table word index |
| lut_rd_en | output | 1 | Table read request |
| lut_rd_idx | output | IDX_W | Table read word index |
| lut_rd_data | input | WORD_W | Read data, valid one cycle after the request |
| lut_wr_en | output | 1 | Table write strobe |
| lut_wr_idx | output | IDX_W | Table write word index |
| lut_wr_data | output | WORD_W | Table write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 misaligned, 2 bad range |
| attr | output | 2 | Query result: 0 secure, 1 non-secure, 2 mixed |

## Verification
The hardest case to reach is a query that ends early. The ports show this only as fewer reads and a shorter busy window than the region's word count implies. To reach it, the bench preloads the table through its own write path so that the first word is uniformly non-secure and the second is uniformly secure. It then counts read strobes and busy cycles, as it does when the first word is itself mixed. A related case is a query whose last word is correct under its partial mask but not as a whole word. The bench sets one up with a last word that holds stray ones above the limit bit.

// File: rtl/lut_attr_pkg.sv
package lut_attr_pkg;
  typedef enum logic [1:0] {
    OP_SET_SEC = 2'd0,
    OP_SET_NS  = 2'd1,
    OP_QUERY   = 2'd2
  } op_t;

  typedef enum logic [1:0] {
    ATTR_SEC = 2'd0,
    ATTR_NS  = 2'd1,
    ATTR_MIX = 2'd2
  } attr_t;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_ALIGN = 2'd1;
  localparam logic [1:0] ERR_RANGE = 2'd2;
endpackage

// File: rtl/lut_attr_decode.sv
module lut_attr_decode #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int EXP_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] limit_addr,
  input  logic [ADDR_W-1:0] rng_base,
  input  logic [ADDR_W-1:0] rng_off,
  input  logic [EXP_W-1:0]  blk_exp,
  input  logic [IDX_W-1:0]  max_word,
  output logic              bad_align,
  output logic              bad_range,
  output logic [IDX_W-1:0]  first_idx,
  output logic [IDX_W-1:0]  last_idx,
  output logic [WORD_W-1:0] first_mask,
  output logic [WORD_W-1:0] last_mask
);
  localparam int SEL_W = $clog2(WORD_W);

  logic [ADDR_W-1:0] low_bits, lim_next, off_b, off_l, blk_b, blk_l, wrd_b, wrd_l, wmax;
  logic [SEL_W-1:0]  sel_b, sel_l;
  logic [WORD_W-1:0] raw_f, raw_l;
  logic              same_word;

  always_comb begin
    low_bits  = ~({ADDR_W{1'b1}} << blk_exp);
    lim_next  = limit_addr + 1'b1;
    bad_align = (|(base_addr & low_bits)) || (|(lim_next & low_bits));

    off_b = base_addr  - rng_base + rng_off;
    off_l = limit_addr - rng_base + rng_off;
    blk_b = off_b >> blk_exp;
    blk_l = off_l >> blk_exp;
    wrd_b = blk_b >> SEL_W;
    wrd_l = blk_l >> SEL_W;
    wmax  = ADDR_W'(max_word);
    bad_range = (blk_b > blk_l) || (wrd_b > wmax) || (wrd_l > wmax);

    sel_b = blk_b[SEL_W-1:0];
    sel_l = blk_l[SEL_W-1:0];
    raw_f = {WORD_W{1'b1}} << sel_b;
    raw_l = {WORD_W{1'b1}} >> (SEL_W'(WORD_W-1) - sel_l);
    same_word = (wrd_b == wrd_l);

    first_idx  = wrd_b[IDX_W-1:0];
    last_idx   = wrd_l[IDX_W-1:0];
    first_mask = same_word ? (raw_f & raw_l) : raw_f;
    last_mask  = same_word ? (raw_f & raw_l) : raw_l;
  end
endmodule

// File: rtl/lut_attr_classify.sv
module lut_attr_classify
  import lut_attr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] masked,
  input  logic [WORD_W-1:0] mask,
  output attr_t             kind
);
  always_comb begin
    if (masked == '0)        kind = ATTR_SEC;
    else if (masked == mask) kind = ATTR_NS;
    else                     kind = ATTR_MIX;
  end
endmodule

// File: rtl/lut_attr_engine.sv
module lut_attr_engine
  import lut_attr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int EXP_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] limit_addr,
  input  logic [ADDR_W-1:0] rng_base,
  input  logic [ADDR_W-1:0] rng_off,
  input  logic [EXP_W-1:0]  blk_exp,
  input  logic [IDX_W-1:0]  max_word,
  output logic              lut_rd_en,
  output logic [IDX_W-1:0]  lut_rd_idx,
  input  logic [WORD_W-1:0] lut_rd_data,
  output logic              lut_wr_en,
  output logic [IDX_W-1:0]  lut_wr_idx,
  output logic [WORD_W-1:0] lut_wr_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic [1:0]        attr
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_MOD, S_FULL} state_t;

  state_t            st;
  logic [IDX_W-1:0]  cur, first_q, last_q, nxt;
  logic [WORD_W-1:0] fmask_q, lmask_q, cur_mask, mod_data, fill_word;
  logic              is_query, set_ns, last_here;
  attr_t             acc_q, cls, q_res, attr_q;

  logic              d_align, d_range;
  logic [IDX_W-1:0]  d_first, d_last;
  logic [WORD_W-1:0] d_fmask, d_lmask;

  lut_attr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .EXP_W(EXP_W), .WORD_W(WORD_W)) u_dec (
    .base_addr(base_addr), .limit_addr(limit_addr), .rng_base(rng_base), .rng_off(rng_off),
    .blk_exp(blk_exp), .max_word(max_word), .bad_align(d_align), .bad_range(d_range),
    .first_idx(d_first), .last_idx(d_last), .first_mask(d_fmask), .last_mask(d_lmask)
  );

  always_comb begin
    if (cur == first_q)     cur_mask = fmask_q;
    else if (cur == last_q) cur_mask = lmask_q;
    else                    cur_mask = '1;
  end

  lut_attr_classify #(.WORD_W(WORD_W)) u_cls (
    .masked(lut_rd_data & cur_mask), .mask(cur_mask), .kind(cls)
  );

  assign nxt       = cur + 1'b1;
  assign last_here = (cur == last_q);
  assign mod_data  = set_ns ? (lut_rd_data | cur_mask) : (lut_rd_data & ~cur_mask);
  assign fill_word = set_ns ? '1 : '0;
  assign q_res     = (cur == first_q) ? cls : ((cls == acc_q) ? cls : ATTR_MIX);
  assign attr      = attr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cur <= '0; first_q <= '0; last_q <= '0;
      fmask_q <= '0; lmask_q <= '0;
      is_query <= 1'b0; set_ns <= 1'b0; acc_q <= ATTR_SEC;
      lut_rd_en <= 1'b0; lut_rd_idx <= '0;
      lut_wr_en <= 1'b0; lut_wr_idx <= '0; lut_wr_data <= '0;
      busy <= 1'b0; done <= 1'b0; err <= ERR_OK; attr_q <= ATTR_SEC;
    end else begin
      lut_rd_en <= 1'b0;
      lut_wr_en <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (d_align || d_range) begin
            done   <= 1'b1;
            err    <= d_align ? ERR_ALIGN : ERR_RANGE;
            attr_q <= ATTR_MIX;
          end else begin
            busy       <= 1'b1;
            is_query   <= op[1];
            set_ns     <= (op == OP_SET_NS);
            first_q    <= d_first;
            last_q     <= d_last;
            fmask_q    <= d_fmask;
            lmask_q    <= d_lmask;
            cur        <= d_first;
            lut_rd_en  <= 1'b1;
            lut_rd_idx <= d_first;
            st         <= S_RD;
          end
        end
        S_RD: st <= S_MOD;
        S_MOD: begin
          if (is_query) begin
            acc_q <= q_res;
            if (q_res == ATTR_MIX || last_here) begin
              busy <= 1'b0; done <= 1'b1; err <= ERR_OK; attr_q <= q_res; st <= S_IDLE;
            end else begin
              cur <= nxt; lut_rd_en <= 1'b1; lut_rd_idx <= nxt; st <= S_RD;
            end
          end else begin
            lut_wr_en   <= 1'b1;
            lut_wr_idx  <= cur;
            lut_wr_data <= mod_data;
            if (last_here) begin
              busy <= 1'b0; done <= 1'b1; err <= ERR_OK; attr_q <= ATTR_MIX; st <= S_IDLE;
            end else begin
              cur <= nxt;
              if (nxt == last_q) begin
                lut_rd_en <= 1'b1; lut_rd_idx <= nxt; st <= S_RD;
              end else begin
                st <= S_FULL;
              end
            end
          end
        end
        S_FULL: begin
          lut_wr_en   <= 1'b1;
          lut_wr_idx  <= cur;
          lut_wr_data <= fill_word;
          cur         <= nxt;
          if (nxt == last_q) begin
            lut_rd_en <= 1'b1; lut_rd_idx <= nxt; st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lut_attr_chk.sv
module lut_attr_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             lut_rd_en,
  input logic [IDX_W-1:0] lut_rd_idx,
  input logic             lut_wr_en,
  input logic [IDX_W-1:0] lut_wr_idx,
  input logic [IDX_W-1:0] max_word,
  input logic             busy,
  input logic             done,
  input logic [1:0]       err
);
  // R13: reads happen only inside an operation
  a_r13_rd_in_busy: assert property (@(posedge clk) disable iff (rst) lut_rd_en |-> busy);
  // R8: every read is followed by a data cycle, never another read
  a_r8_rd_single: assert property (@(posedge clk) disable iff (rst) lut_rd_en |=> !lut_rd_en);
  // R13: read and write never target the same word together
  a_r13_rdwr_apart: assert property (@(posedge clk) disable iff (rst)
    (lut_rd_en && lut_wr_en) |-> (lut_rd_idx != lut_wr_idx));
  // R1, R3: an error completion carries no table access
  a_r1_err_no_access: assert property (@(posedge clk) disable iff (rst)
    (done && err != 2'd0) |-> (!lut_wr_en && !lut_rd_en));
  // R4: reads stay within the allowed word index
  a_r4_rd_bound: assert property (@(posedge clk) disable iff (rst)
    lut_rd_en |-> (lut_rd_idx <= max_word));
  // R13: completion is reported only once busy has dropped
  a_r13_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
endmodule

bind lut_attr_engine lut_attr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lut_rd_en(lut_rd_en), .lut_rd_idx(lut_rd_idx),
  .lut_wr_en(lut_wr_en), .lut_wr_idx(lut_wr_idx), .max_word(max_word),
  .busy(busy), .done(done), .err(err)
);

// File: tb/tb_lut_attr_engine.sv
`timescale 1ns/1ps
module tb_lut_attr_engine;
  localparam int AW = 32, IW = 8, EW = 5, WW = 32, NW = 1 << IW;
  localparam logic [31:0] RB = 32'h2000_0000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] base_addr = '0, limit_addr = '0, rng_base = RB, rng_off = '0;
  logic [EW-1:0] blk_exp = 5'd5;
  logic [IW-1:0] max_word = 8'd63;
  logic lut_rd_en, lut_wr_en, busy, done;
  logic [IW-1:0] lut_rd_idx, lut_wr_idx;
  logic [WW-1:0] lut_rd_data, lut_wr_data;
  logic [1:0] err, attr;

  logic [WW-1:0] mem [NW];
  logic [WW-1:0] exp_mem [NW];
  logic tb_we = 1'b0;
  logic [IW-1:0] tb_wi = '0;
  logic [WW-1:0] tb_wd = '0;

  int checks = 0, errors = 0;
  int rd_cnt, wr_cnt, done_cnt, busy_cyc;
  logic mon_on = 1'b0;
  logic [1:0] got_err, got_attr;

  always #2.5 clk = ~clk;

  lut_attr_engine #(.ADDR_W(AW), .IDX_W(IW), .EXP_W(EW), .WORD_W(WW)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .base_addr(base_addr), .limit_addr(limit_addr),
    .rng_base(rng_base), .rng_off(rng_off), .blk_exp(blk_exp), .max_word(max_word),
    .lut_rd_en(lut_rd_en), .lut_rd_idx(lut_rd_idx), .lut_rd_data(lut_rd_data),
    .lut_wr_en(lut_wr_en), .lut_wr_idx(lut_wr_idx), .lut_wr_data(lut_wr_data),
    .busy(busy), .done(done), .err(err), .attr(attr)
  );

  always @(posedge clk) begin
    if (lut_rd_en) lut_rd_data <= mem[lut_rd_idx];
    if (lut_wr_en) mem[lut_wr_idx] <= lut_wr_data;
    else if (tb_we) mem[tb_wi] <= tb_wd;
  end

  always @(negedge clk) if (mon_on) begin
    rd_cnt   += int'(lut_rd_en);
    wr_cnt   += int'(lut_wr_en);
    done_cnt += int'(done);
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic fill(input int w, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_wi = IW'(w); tb_wd = v;
    exp_mem[w] = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [31:0] ba(input int b);
    return RB + 32'(b) * 32;
  endfunction

  function automatic logic [31:0] la(input int b);
    return RB + 32'(b + 1) * 32 - 1;
  endfunction

  task automatic model_set(input int bb, input int bl, input logic ns);
    for (int b = bb; b <= bl; b++) exp_mem[b / 32][b % 32] = ns;
  endtask

  function automatic logic [1:0] model_query(input int bb, input int bl);
    int ones = 0;
    for (int b = bb; b <= bl; b++) ones += int'(exp_mem[b / 32][b % 32]);
    if (ones == 0) return 2'd0;
    if (ones == bl - bb + 1) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check_mem(input string tag);
    int bad = -1;
    for (int w = 0; w < 20; w++) if (bad < 0 && mem[w] !== exp_mem[w]) bad = w;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s word %0d actual=%0h expected=%0h", tag, bad, mem[bad], exp_mem[bad]);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] b, input logic [31:0] l,
                        input logic [7:0] mw);
    int wd = 0;
    @(negedge clk);
    op = o; base_addr = b; limit_addr = l; max_word = mw; start = 1'b1;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b0; busy_cyc = 0;
    while (!done && wd < 2000) begin
      if (busy) busy_cyc++;
      @(negedge clk);
      wd++;
    end
    if (wd >= 2000) begin
      errors++;
      $display("FAIL watchdog op: actual=no done expected=done");
    end
    got_err = err; got_attr = attr;
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic t_reset;
    check("R12 busy", 32'(busy), 0);
    check("R12 done", 32'(done), 0);
    check("R12 ports", 32'({lut_rd_en, lut_wr_en}), 0);
    check("R12 err/attr", 32'({err, attr}), 0);
  endtask

  task automatic t_set_ns_multi;
    for (int w = 0; w < 20; w++) fill(w, 32'h0);
    run_op(2'd1, ba(5), la(100), 8'd63);
    model_set(5, 100, 1'b1);
    check("R5 err", 32'(got_err), 0);
    check("R8 busy cycles 4 words", busy_cyc, 6);
    check("R8 reads", rd_cnt, 2);
    check("R8 writes", wr_cnt, 4);
    check_mem("R5 ns region");
  endtask

  task automatic t_set_sec_multi;
    for (int w = 0; w < 8; w++) fill(w, 32'hFFFF_FFFF);
    fill(1, 32'hA5A5_3C3C);
    run_op(2'd0, ba(40), la(170), 8'd63);
    model_set(40, 170, 1'b0);
    check("R6 busy cycles 5 words", busy_cyc, 7);
    check("R8 writes 5 words", wr_cnt, 5);
    check_mem("R6 secure region");
  endtask

  task automatic t_single_word;
    fill(2, 32'h1234_5678);
    run_op(2'd1, ba(67), la(73), 8'd63);
    model_set(67, 73, 1'b1);
    check("R7 single word busy", busy_cyc, 2);
    check("R8 single word writes", wr_cnt, 1);
    check_mem("R7 inner mask");
    run_op(2'd0, ba(96), la(127), 8'd63);
    model_set(96, 127, 1'b0);
    check_mem("R7 full word to bit 31");
    run_op(2'd1, ba(10), la(95), 8'd63);
    model_set(10, 95, 1'b1);
    check("R8 busy 3 words", busy_cyc, 5);
    check_mem("R7 last mask all ones");
  endtask

  task automatic t_query;
    fill(8, 32'h0); fill(9, 32'h0); fill(10, 32'hFFFF_FFFF); fill(11, 32'h0000_00F0);
    fill(12, 32'hFFFF_FFFF); fill(13, 32'h0); fill(14, 32'hFFFF_FFFF); fill(15, 32'hF000_000F);
    run_op(2'd2, ba(256), la(319), 8'd63);
    check("R9 query secure", 32'(got_attr), 32'(model_query(256, 319)));
    check("R10 two words busy", busy_cyc, 4);
    run_op(2'd2, ba(320), la(351), 8'd63);
    check("R9 query ns", 32'(got_attr), 1);
    run_op(2'd3, ba(356), la(359), 8'd63);
    check("R9 query ns partial op3", 32'(got_attr), 1);
    run_op(2'd2, ba(355), la(359), 8'd63);
    check("R9 query mixed", 32'(got_attr), 2);
    run_op(2'd2, ba(448), la(483), 8'd63);
    check("R9 last word under its mask", 32'(got_attr), 32'(model_query(448, 483)));
    run_op(2'd2, ba(384), la(511), 8'd63);
    check("R10 early attr", 32'(got_attr), 2);
    check("R10 early reads", rd_cnt, 2);
    check("R10 early busy", busy_cyc, 4);
    run_op(2'd2, ba(352), la(415), 8'd63);
    check("R10 first word mixed reads", rd_cnt, 1);
    check("R10 first word mixed busy", busy_cyc, 2);
    check_mem("R9 query leaves table");
  endtask

  task automatic t_errors;
    run_op(2'd1, ba(4) + 4, la(20), 8'd63);
    check("R1 base misaligned", 32'(got_err), 1);
    check("R1 no access", 32'(rd_cnt + wr_cnt + busy_cyc), 0);
    check("R13 done pulses", done_cnt, 1);
    run_op(2'd0, ba(4), ba(10) - 2, 8'd63);
    check("R1 limit misaligned", 32'(got_err), 1);
    run_op(2'd1, ba(10), la(5), 8'd63);
    check("R3 base after limit", 32'(got_err), 2);
    check("R3 no access", 32'(rd_cnt + wr_cnt), 0);
    run_op(2'd1, ba(0), la(100), 8'd2);
    check("R4 word over max", 32'(got_err), 2);
    check("R4 no access", 32'(rd_cnt + wr_cnt), 0);
    run_op(2'd1, ba(0), la(100), 8'd3);
    model_set(0, 100, 1'b1);
    check("R4 word equal max ok", 32'(got_err), 0);
    check("R13 update attr", 32'(got_attr), 2);
    check_mem("R4 accepted at max");
    check_mem("R1 R3 table untouched");
  endtask

  task automatic t_offset;
    fill(16, 32'h0); fill(17, 32'h0);
    rng_base = 32'h3000_0000; rng_off = 32'h0000_4000;
    run_op(2'd1, 32'h3000_0000, 32'h3000_007F, 8'd63);
    exp_mem[16] = 32'h0000_000F;
    check("R2 offset err", 32'(got_err), 0);
    check_mem("R2 normalized index");
    rng_base = RB; rng_off = '0;
  endtask

  task automatic t_start_busy;
    int wd = 0;
    for (int w = 0; w < 8; w++) fill(w, 32'h0);
    @(negedge clk);
    op = 2'd1; base_addr = ba(0); limit_addr = la(223); max_word = 8'd63; start = 1'b1;
    done_cnt = 0; mon_on = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    op = 2'd0; base_addr = ba(0); limit_addr = la(255); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    repeat (15) @(negedge clk);
    mon_on = 1'b0;
    model_set(0, 223, 1'b1);
    check("R11 single done", done_cnt, 1);
    check_mem("R11 second start ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_set_ns_multi;
    t_set_sec_multi;
    t_single_word;
    t_query;
    t_errors;
    t_offset;
    t_start_busy;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule